// File: doc/BRIEF.md
# Record List Trigger Sequencer

This block walks a fixed-length list of conversion records on behalf of a downstream conversion engine. A trigger starts the work. A 3-bit mode field decides two things: whether the trigger runs the whole list back to back (scan) or handles only the next record (single step), and which interrupt policy applies. For each conversion the block sends a one-cycle start pulse with the record index and then waits for the engine's done pulse. When accumulation is enabled, one record takes several conversions. The engine returns a comparator-hit bit and a per-record interrupt command bit with the done pulse that completes the record.

The block raises a one-cycle list interrupt pulse according to the mode, and also whenever a completed record carries the command bit. A busy flag acknowledges the trigger for as long as the triggered work is in progress. Triggers that arrive while the block is busy are dropped. The mode and accumulation inputs must be held stable while the block is busy.

Top module: `rec_list_seq`

## Requirements
- R1: After reset, conv_start_o, busy_o and list_irq_o are 0 and rec_idx_o is 0.
- R2: A trigger is accepted only while busy_o is 0. busy_o goes high in the cycle after an accepted trigger and stays high until the cycle after the done pulse that completes the last record of the run. A trigger seen while busy has no effect.
- R3: Every conversion request is a single-cycle conv_start_o pulse while busy_o is 1, with rec_idx_o naming the record. The first pulse comes in the cycle after the accepted trigger. Each later pulse comes in the cycle after the preceding non-final done.
- R4: With acc_en_i=1 a record completes on its (acc_num_i+1)-th done pulse. With acc_en_i=0 it completes on the first. cmp_hit_i and rec_irq_cmd_i are used only on the completing done pulse.
- R5: If mode bit 2 is 1 (modes 4 to 7), one trigger processes records 0 through N_REC-1 in order.
- R6: If mode bit 2 is 0 (modes 0 to 3), one trigger processes only the record at rec_idx_o. The index then advances by one and wraps from N_REC-1 to 0. A scan also leaves the index at 0.
- R7: Modes 0, 3 and 4 raise no interrupt from the mode policy.
- R8: Mode 1 raises an interrupt for every completed record. Modes 2 and 5 raise one only when record N_REC-1 completes.
- R9: Mode 6 raises an interrupt for every completed record whose cmp_hit_i is 1.
- R10: Mode 7 raises an interrupt when record N_REC-1 completes, but only if at least one record of the current scan had cmp_hit_i=1. This match memory is cleared when each scan is accepted.
- R11: A completed record with rec_irq_cmd_i=1 raises an interrupt in every mode.
- R12: list_irq_o is a one-cycle pulse in the cycle after the completing done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | List trigger |
| mode_i | input | 3 | Advance and interrupt mode |
| acc_en_i | input | 1 | Accumulation enable |
| acc_num_i | input | ACC_W | Accumulations per record minus one |
| conv_done_i | input | 1 | Conversion done pulse from engine |
| cmp_hit_i | input | 1 | Comparator criteria met, valid with done |
| rec_irq_cmd_i | input | 1 | Record interrupt command, valid with done |
| conv_start_o | output | 1 | Conversion request pulse |
| rec_idx_o | output | IDX_W | Current record index |
| busy_o | output | 1 | Trigger acknowledge / processing in progress |
| list_irq_o | output | 1 | List interrupt pulse |

## Verification
If the accumulation count is wrong, a start pulse appears or goes missing in the cycle after a done, so the error shows within one conversion. If the record index is wrong, rec_idx_o at the next start pulse is wrong, or the scan ends early or late, which shows in busy_o. A stale or uncleared match memory in mode 7 only shows when the last record of a scan completes. For that reason the sweep runs a scan with no hits directly after a scan with hits.

// File: rtl/rls_pkg.sv
package rls_pkg;
  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} seq_state_t;

  localparam logic [2:0] M_STEP_QUIET = 3'd0;
  localparam logic [2:0] M_STEP_EACH  = 3'd1;
  localparam logic [2:0] M_STEP_END   = 3'd2;
  localparam logic [2:0] M_SCAN_QUIET = 3'd4;
  localparam logic [2:0] M_SCAN_END   = 3'd5;
  localparam logic [2:0] M_SCAN_HIT   = 3'd6;
  localparam logic [2:0] M_SCAN_ANY   = 3'd7;

  function automatic logic mode_is_scan(input logic [2:0] m);
    return m[2];
  endfunction
endpackage

// File: rtl/rls_acc_counter.sv
module rls_acc_counter #(
  parameter int ACC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [ACC_W-1:0] target,
  output logic             last_acc
);
  logic [ACC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || inc) cnt_q <= cnt_d;
  end

  assign last_acc = (cnt_q == target);
endmodule

// File: rtl/rls_index.sv
module rls_index #(
  parameter int N_REC = 4,
  parameter int IDX_W = (N_REC > 1) ? $clog2(N_REC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             is_last
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_REC - 1);
  logic [IDX_W-1:0] idx_q, idx_inc, idx_d;

  generate
    if ((1 << IDX_W) == N_REC) begin : g_pow2
      assign idx_inc = idx_q + 1'b1;
    end else begin : g_cmp
      assign idx_inc = (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  endgenerate

  always_comb begin
    idx_d = idx_q;
    if (clr)      idx_d = '0;
    else if (adv) idx_d = idx_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx_q <= '0;
    else if (clr || adv) idx_q <= idx_d;
  end

  assign idx     = idx_q;
  assign is_last = (idx_q == LAST);
endmodule

// File: rtl/rls_irq_policy.sv
module rls_irq_policy
  import rls_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       is_last,
  input  logic       hit,
  input  logic       any_hit_q,
  input  logic       cmd,
  output logic       irq_req
);
  logic by_mode;

  always_comb begin
    unique case (mode)
      M_STEP_EACH: by_mode = 1'b1;
      M_STEP_END,
      M_SCAN_END:  by_mode = is_last;
      M_SCAN_HIT:  by_mode = hit;
      M_SCAN_ANY:  by_mode = is_last && (any_hit_q || hit);
      default:     by_mode = 1'b0;
    endcase
  end

  assign irq_req = by_mode || cmd;
endmodule

// File: rtl/rec_list_seq.sv
module rec_list_seq
  import rls_pkg::*;
#(
  parameter int N_REC = 4,
  parameter int ACC_W = 4,
  parameter int IDX_W = (N_REC > 1) ? $clog2(N_REC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [2:0]       mode_i,
  input  logic             acc_en_i,
  input  logic [ACC_W-1:0] acc_num_i,
  input  logic             conv_done_i,
  input  logic             cmp_hit_i,
  input  logic             rec_irq_cmd_i,
  output logic             conv_start_o,
  output logic [IDX_W-1:0] rec_idx_o,
  output logic             busy_o,
  output logic             list_irq_o
);
  seq_state_t state_q, state_d;
  logic start_q, start_d, irq_q, irq_d, any_q, any_d;
  logic accept, scan, last_acc, is_last, rec_done, acc_step, more, irq_req;
  logic [ACC_W-1:0] acc_target;

  assign scan       = mode_is_scan(mode_i);
  assign accept     = (state_q == S_IDLE) && trig_i;
  assign acc_target = acc_en_i ? acc_num_i : '0;
  assign rec_done   = (state_q == S_RUN) && conv_done_i && last_acc;
  assign acc_step   = (state_q == S_RUN) && conv_done_i && !last_acc;
  assign more       = rec_done && scan && !is_last;

  rls_acc_counter #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(accept || rec_done), .inc(acc_step),
    .target(acc_target), .last_acc(last_acc)
  );

  rls_index #(.N_REC(N_REC), .IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr(accept && scan), .adv(rec_done),
    .idx(rec_idx_o), .is_last(is_last)
  );

  rls_irq_policy u_pol (
    .mode(mode_i), .is_last(is_last), .hit(cmp_hit_i), .any_hit_q(any_q),
    .cmd(rec_irq_cmd_i), .irq_req(irq_req)
  );

  always_comb begin
    state_d = state_q;
    if (accept)                 state_d = S_RUN;
    else if (rec_done && !more) state_d = S_IDLE;
    start_d = accept || acc_step || more;
    irq_d   = rec_done && irq_req;
    any_d   = any_q;
    if (accept)                      any_d = 1'b0;
    else if (rec_done && cmp_hit_i)  any_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
      any_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      irq_q   <= irq_d;
      if (accept || rec_done) any_q <= any_d;
    end
  end

  assign conv_start_o = start_q;
  assign busy_o       = (state_q == S_RUN);
  assign list_irq_o   = irq_q;
endmodule

// File: rtl/rls_checker.sv
module rls_checker #(
  parameter int N_REC = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_i,
  input logic [2:0]       mode_i,
  input logic             conv_done_i,
  input logic             rec_irq_cmd_i,
  input logic             conv_start_o,
  input logic [IDX_W-1:0] rec_idx_o,
  input logic             busy_o,
  input logic             list_irq_o
);
  p_start_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> busy_o);
  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);
  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(trig_i));
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !conv_done_i) |=> busy_o);
  p_busy_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(conv_done_i));
  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_idx_o <= IDX_W'(N_REC - 1));
  p_irq_after_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    list_irq_o |-> $past(conv_done_i));
  p_irq_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    list_irq_o |=> !list_irq_o);
  p_quiet_modes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (list_irq_o && (mode_i == 3'd0 || mode_i == 3'd3 || mode_i == 3'd4))
      |-> $past(rec_irq_cmd_i));
endmodule

bind rec_list_seq rls_checker #(.N_REC(N_REC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .mode_i(mode_i),
  .conv_done_i(conv_done_i), .rec_irq_cmd_i(rec_irq_cmd_i),
  .conv_start_o(conv_start_o), .rec_idx_o(rec_idx_o), .busy_o(busy_o),
  .list_irq_o(list_irq_o)
);

// File: tb/sim_rec_list_seq.sv
module sim_rec_list_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int AW = 4;
  localparam int IW = 2;
  localparam int WD_LIMIT = 150000;

  logic clk, rst_n, trig, acc_en, done, hit, cmd;
  logic [2:0] mode;
  logic [AW-1:0] acc_num;
  logic start, busy, irq;
  logic [IW-1:0] idx;

  int n_chk = 0, n_bad = 0, cyc = 0, exp_idx = 0;
  bit finished = 0;

  rec_list_seq #(.N_REC(N), .ACC_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .mode_i(mode), .acc_en_i(acc_en),
    .acc_num_i(acc_num), .conv_done_i(done), .cmp_hit_i(hit),
    .rec_irq_cmd_i(cmd), .conv_start_o(start), .rec_idx_o(idx),
    .busy_o(busy), .list_irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act cycles=%0d exp below %0d", cyc, WD_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_irq(input int m, input bit last, input bit h,
                                 input bit anyh, input bit c);
    bit r;
    case (m)
      1: r = 1;
      2, 5: r = last;
      6: r = h;
      7: r = last && (anyh || h);
      default: r = 0; // R7 quiet modes 0, 3, 4
    endcase
    return r || c; // R11 command bit
  endfunction

  task automatic run_trig(input int m, input bit ae, input int an,
                          input bit [3:0] hp, input bit [3:0] cp);
    int nrec, req, r;
    bit sc, anyh, e;
    @(negedge clk);
    mode = 3'(m); acc_en = ae; acc_num = AW'(an); trig = 1;
    @(negedge clk);
    trig = 0;
    sc = (m >= 4);
    if (sc) exp_idx = 0;             // R5 scan starts at record 0
    nrec = sc ? N : 1;
    anyh = 0;
    for (int k = 0; k < nrec; k++) begin
      r = exp_idx;
      req = ae ? an + 1 : 1;         // R4
      for (int a = 0; a < req; a++) begin
        chk(start == 1, "R3 start pulse", int'(start), 1);
        chk(busy == 1, "R2 busy while running", int'(busy), 1);
        chk(int'(idx) == r, "R6 record index", int'(idx), r);
        if (k == 0 && a == 0) trig = 1; // R2 trigger while busy
        @(negedge clk);
        trig = 0;
        chk(start == 0, "R3 start single cycle", int'(start), 0);
        chk(irq == 0, "R12 no irq while waiting", int'(irq), 0);
        done = 1;
        hit = (a == req - 1) ? hp[r] : ~hp[r]; // R4 non-final values ignored
        cmd = (a == req - 1) ? cp[r] : ~cp[r];
        @(negedge clk);
        done = 0; hit = 0; cmd = 0;
        if (a < req - 1)
          chk(irq == 0, "R4 no irq on partial accumulation", int'(irq), 0);
      end
      e = exp_irq(m, r == N - 1, hp[r], anyh, cp[r]);
      chk(irq == e, "R8 R9 R10 R11 list irq", int'(irq), int'(e));
      anyh |= hp[r];
      exp_idx = (r == N - 1) ? 0 : r + 1;
      chk(busy == (k < nrec - 1), "R2 busy end", int'(busy), int'(k < nrec - 1));
    end
    @(negedge clk);
    chk(irq == 0, "R12 irq one cycle", int'(irq), 0);
    chk(start == 0 && busy == 0, "R2 ignored trigger left no work",
        int'({start, busy}), 0);
    chk(int'(idx) == exp_idx, "R6 index after run", int'(idx), exp_idx);
  endtask

  initial begin
    rst_n = 0; trig = 0; mode = 0; acc_en = 0; acc_num = 0;
    done = 0; hit = 0; cmd = 0;
    repeat (3) @(negedge clk);
    chk(start == 0 && busy == 0 && irq == 0 && idx == 0, "R1 reset state",
        int'({start, busy, irq, idx}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(start == 0 && busy == 0 && irq == 0 && idx == 0, "R1 after release",
        int'({start, busy, irq, idx}), 0);
    for (int m = 0; m < 8; m++)
      for (int ac = 0; ac < 3; ac++)
        for (int ci = 0; ci < 2; ci++)
          for (int hp = 0; hp < 16; hp++) begin
            bit [3:0] h4, c4;
            h4 = 4'(hp);
            c4 = (ci == 0) ? 4'b0000 : (h4 ^ 4'b0110);
            if (m < 4) begin
              for (int t = 0; t < N + 1; t++)  // R6 wrap
                run_trig(m, ac != 0, (ac == 2) ? 2 : 0, h4, c4);
            end else begin
              run_trig(m, ac != 0, (ac == 2) ? 2 : 0, h4, c4);
            end
          end
    run_trig(7, 1, 15, 4'b0010, 4'b0000);  // R4 maximum count, R10
    run_trig(7, 1, 15, 4'b0000, 4'b0000);  // R10 memory cleared
    run_trig(1, 1, 15, 4'b0000, 4'b0000);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule